// File: doc/BRIEF.md
# Dual-Select Serial Register and Data Queue Port

This block is the host-facing serial slave of a radio transceiver. It has two active-low selects. One select opens a bank of 8-bit configuration registers. The other opens a 64-byte data queue, which the host fills before a transmission or drains after a reception. When both selects are low, the configuration select takes the transaction. The serial output driver is enabled while either select is low.

Register 0 holds the chip-mode field in bits 7:5. The block decodes this field and presents it as the mode output for the rest of the transceiver. The radio side of the queue uses a push port and a pop port. The chip mode decides which side fills the queue and which side drains it.

The serial pins are sampled on the block clock. The clock must run several times faster than the serial clock, and the serial pins are expected to be synchronous to it already.

Top module: `spi_dual_port`

## Requirements
- R1: The serial bus uses mode 0 (data sampled on the rising serial clock edge, output changed on the falling edge) and sends the most significant bit first. The first byte of a configuration access is a header: bit 7 is 1 for a read and 0 for a write, bits 4:0 are the register address, and bits 6:5 are ignored. The second byte is either the write data or, for a read, the register value shifted out on `miso`. Any further bytes in the same access have no effect.
- R2: When both selects are low, the transaction is a configuration access and the data queue is not touched.
- R3: `miso_oe` is 1 whenever either select is low and 0 otherwise. `miso` is 0 while `miso_oe` is 0.
- R4: After reset, register 0 reads 0x20, every other register reads 0x00, `mode_o` is 001, the queue is empty with a count of 0, and the overflow flag is 0.
- R5: `mode_o` follows register 0 bits 7:5 with these codes: 000 sleep, 001 standby, 010 synthesizer, 011 receive, 100 transmit. A write to register 0 whose bits 7:5 hold 101, 110 or 111 keeps the old mode bits but still writes bits 4:0.
- R6: Register contents are kept in every mode, including sleep. The serial port stays usable while in sleep.
- R7: In receive mode (011), the host reads the queue through the data select, the radio push port is accepted, and the radio pop port is ignored. In every other mode, the host writes the queue through the data select, the radio pop port removes bytes, and the radio push port is ignored.
- R8: While the data select is low, every 8 serial clock rises complete one byte. If the select is released part-way through a byte, that byte is discarded and the count does not change.
- R9: The queue holds 64 bytes. `fifo_full` is 1 exactly at a count of 64, `fifo_empty` is 1 exactly at a count of 0, and `fifo_count` gives the count.
- R10: A push while the queue is full is dropped and sets `fifo_ovf`. `fifo_ovf` stays set until reset.
- R11: A host read while the queue is empty shifts out 0x00 and leaves the count at 0. `rf_pop_data` is 0x00 while the queue is empty, and a radio pop on an empty queue changes nothing.
- R12: Bytes leave the queue in the order they entered it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel_n | input | 1 | Active-low select for configuration access |
| dat_sel_n | input | 1 | Active-low select for data queue access |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the serial data driver |
| mode_o | output | 3 | Decoded chip mode |
| rf_push | input | 1 | Radio side: push a received byte |
| rf_push_data | input | 8 | Radio side: byte to push |
| rf_pop | input | 1 | Radio side: take the head byte for transmission |
| rf_pop_data | output | 8 | Radio side: head byte, or 0x00 when empty |
| fifo_full | output | 1 | Queue holds 64 bytes |
| fifo_empty | output | 1 | Queue holds no bytes |
| fifo_count | output | 7 | Number of bytes in the queue |
| fifo_ovf | output | 1 | Sticky flag for a dropped push |

## Verification
The hardest case to reach from the ports is a host read burst that crosses a byte boundary. At that boundary, the byte just finished leaves the queue in the same cycle that the following byte must be loaded for shifting. The stimulus drives this case with long multi-byte read bursts in receive mode, on a queue filled by the radio push port, and draws the queue down to one byte and then to zero within the burst. Overflow is reached with one 65-byte write burst. A fixed-seed random mix of register writes (including illegal mode codes), register reads, partial bytes and radio-side traffic then moves the block through every direction of the queue.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_CFG  = 2'd1,
        ACC_DAT  = 2'd2
    } access_e;

    typedef enum logic [2:0] {
        MODE_SLEEP = 3'd0,
        MODE_STBY  = 3'd1,
        MODE_SYNTH = 3'd2,
        MODE_RX    = 3'd3,
        MODE_TX    = 3'd4
    } chip_mode_e;

    typedef struct packed {
        logic       rd;
        logic [1:0] spare;
        logic [4:0] addr;
    } cfg_hdr_t;

    // configuration select has priority over data select
    function automatic access_e pick_access(input logic cfg_n, input logic dat_n);
        if (!cfg_n)      return ACC_CFG;
        else if (!dat_n) return ACC_DAT;
        else             return ACC_NONE;
    endfunction

    function automatic logic mode_code_ok(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
    import spi_dual_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              mosi,
    input  access_e           acc,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              load_now,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [1:0]        byte_idx,
    output logic              miso_bit
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sck_q;
    access_e           acc_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] sh_in;
    logic [BYTE_W-1:0] sh_out;
    logic              start;
    logic              rise;
    logic              fall;

    always_comb begin
        start     = (acc != acc_q);
        rise      = sck & ~sck_q;
        fall      = ~sck & sck_q;
        rx_byte   = {sh_in[BYTE_W-2:0], mosi};
        byte_done = !start && (acc != ACC_NONE) && rise
                    && (bit_cnt == CNT_W'(BYTE_W - 1));
        load_now  = (start && (acc != ACC_NONE)) || byte_done;
        miso_bit  = sh_out[BYTE_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            acc_q    <= ACC_NONE;
            bit_cnt  <= '0;
            sh_in    <= '0;
            sh_out   <= '0;
            byte_idx <= '0;
        end else begin
            sck_q <= sck;
            acc_q <= acc;
            if (start) begin
                bit_cnt  <= '0;
                byte_idx <= '0;
                sh_in    <= '0;
                sh_out   <= (acc != ACC_NONE) ? load_byte : '0;
            end else if (acc != ACC_NONE) begin
                if (rise) begin
                    sh_in   <= rx_byte;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (byte_done) begin
                        sh_out <= load_byte;
                        if (byte_idx != 2'd3) byte_idx <= byte_idx + 1'b1;
                    end
                end else if (fall && bit_cnt != '0) begin
                    sh_out <= {sh_out[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    AST_IDLE_CNT: assert property (@(posedge clk) disable iff (rst)
        (acc_q == ACC_NONE) |-> (bit_cnt == '0)); // R8

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import spi_dual_pkg::*;
#(
    parameter int          NREGS     = 32,
    parameter logic [7:0]  MODE0_RST = 8'h20,
    localparam int         AW        = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output chip_mode_e        mode
);
    logic [BYTE_W-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g == 0) begin : g_mode
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[g] <= MODE0_RST;
                end else if (wr_en && wr_addr == AW'(g)) begin
                    regs[g][4:0] <= wr_data[4:0];
                    if (mode_code_ok(wr_data[7:5])) regs[g][7:5] <= wr_data[7:5];
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)                               regs[g] <= '0;
                else if (wr_en && wr_addr == AW'(g))   regs[g] <= wr_data;
            end
        end
    end

    assign rd_data = regs[rd_addr];
    assign mode    = chip_mode_e'(regs[0][7:5]);

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode_code_ok(regs[0][7:5])); // R5

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo
    import spi_dual_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = PW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop,
    output logic [BYTE_W-1:0] head,
    output logic [BYTE_W-1:0] head_next,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty,
    output logic              ovf
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;
    logic              do_push;
    logic              do_pop;

    always_comb begin
        full      = (count == CW'(DEPTH));
        empty     = (count == '0);
        do_push   = push && !full;
        do_pop    = pop && !empty;
        head      = mem[rd_ptr];
        head_next = mem[rd_ptr + 1'b1];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full) ovf <= 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R9
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == CW'(DEPTH)) && ovf); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf); // R10
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty); // R11

endmodule

// File: rtl/spi_dual_port.sv
module spi_dual_port
    import spi_dual_pkg::*;
#(
    parameter  int NREGS = 32,
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(NREGS),
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_sel_n,
    input  logic          dat_sel_n,
    input  logic          sck,
    input  logic          mosi,
    output logic          miso,
    output logic          miso_oe,
    output logic [2:0]    mode_o,
    input  logic          rf_push,
    input  logic [7:0]    rf_push_data,
    input  logic          rf_pop,
    output logic [7:0]    rf_pop_data,
    output logic          fifo_full,
    output logic          fifo_empty,
    output logic [CW-1:0] fifo_count,
    output logic          fifo_ovf
);
    access_e           acc;
    logic              load_now;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic [1:0]        byte_idx;
    logic              miso_bit;
    logic [BYTE_W-1:0] load_byte;

    cfg_hdr_t          hdr_q;
    logic              slot_full_q;
    chip_mode_e        mode;
    logic              rx_dir;
    logic [BYTE_W-1:0] reg_rd_data;
    logic              reg_wr;

    logic              spi_push;
    logic              spi_pop;
    logic              q_push;
    logic [BYTE_W-1:0] q_push_data;
    logic              q_pop;
    logic [BYTE_W-1:0] q_head;
    logic [BYTE_W-1:0] q_head_next;
    logic              next_avail;
    logic [BYTE_W-1:0] next_head;

    assign acc = pick_access(cfg_sel_n, dat_sel_n);

    spi_byte_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .sck       (sck),
        .mosi      (mosi),
        .acc       (acc),
        .load_byte (load_byte),
        .load_now  (load_now),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .byte_idx  (byte_idx),
        .miso_bit  (miso_bit)
    );

    cfg_reg_bank #(.NREGS(NREGS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_addr (hdr_q.addr[AW-1:0]),
        .wr_data (rx_byte),
        .rd_addr (rx_byte[AW-1:0]),
        .rd_data (reg_rd_data),
        .mode    (mode)
    );

    byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push),
        .push_data (q_push_data),
        .pop       (q_pop),
        .head      (q_head),
        .head_next (q_head_next),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .ovf       (fifo_ovf)
    );

    always_comb begin
        rx_dir      = (mode == MODE_RX);
        reg_wr      = (acc == ACC_CFG) && byte_done && (byte_idx == 2'd1) && !hdr_q.rd;
        spi_push    = (acc == ACC_DAT) && byte_done && !rx_dir;
        spi_pop     = (acc == ACC_DAT) && byte_done && rx_dir && slot_full_q;
        q_push      = rx_dir ? rf_push : spi_push;
        q_push_data = rx_dir ? rf_push_data : rx_byte;
        q_pop       = rx_dir ? spi_pop : rf_pop;
        // byte presented in the next host read slot, after any pop this cycle
        next_avail  = spi_pop ? (fifo_count >= CW'(2)) : !fifo_empty;
        next_head   = spi_pop ? q_head_next : q_head;
        load_byte   = '0;
        case (acc)
            ACC_CFG: if (byte_done && byte_idx == 2'd0 && rx_byte[7]) load_byte = reg_rd_data;
            ACC_DAT: if (rx_dir && next_avail)                        load_byte = next_head;
            default: load_byte = '0;
        endcase
        miso_oe     = !cfg_sel_n || !dat_sel_n;
        miso        = (acc != ACC_NONE) ? miso_bit : 1'b0;
        mode_o      = mode;
        rf_pop_data = fifo_empty ? '0 : q_head;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q       <= '0;
            slot_full_q <= 1'b0;
        end else begin
            if (acc == ACC_CFG && byte_done && byte_idx == 2'd0) hdr_q <= cfg_hdr_t'(rx_byte);
            if (acc == ACC_NONE)  slot_full_q <= 1'b0;
            else if (load_now)    slot_full_q <= (acc == ACC_DAT) && rx_dir && next_avail;
        end
    end

    AST_CFG_WINS: assert property (@(posedge clk) disable iff (rst)
        !cfg_sel_n |-> !(spi_push || spi_pop)); // R2
    AST_READ_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (fifo_empty && !q_push) |=> fifo_empty); // R11

endmodule

// File: tb/spi_dual_port_tb_top.sv
module spi_dual_port_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       cfg_sel_n = 1'b1, dat_sel_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic       miso, miso_oe;
    logic [2:0] mode_o;
    logic       rf_push = 1'b0, rf_pop = 1'b0;
    logic [7:0] rf_push_data = 8'h00, rf_pop_data;
    logic       fifo_full, fifo_empty, fifo_ovf;
    logic [6:0] fifo_count;

    spi_dual_port dut_i (
        .clk(clk), .rst(rst), .cfg_sel_n(cfg_sel_n), .dat_sel_n(dat_sel_n),
        .sck(sck), .mosi(mosi), .miso(miso), .miso_oe(miso_oe), .mode_o(mode_o),
        .rf_push(rf_push), .rf_push_data(rf_push_data), .rf_pop(rf_pop),
        .rf_pop_data(rf_pop_data), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .fifo_count(fifo_count), .fifo_ovf(fifo_ovf)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] m_regs [32];
    logic [7:0] m_q [$];
    bit         m_ovf = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit m_rx();
        return m_regs[0][7:5] == 3'd3;
    endfunction

    function automatic void m_push(input logic [7:0] b);
        if (m_q.size() < 64) m_q.push_back(b);
        else m_ovf = 1;
    endfunction

    task automatic spi_bit(input logic b, output logic r);
        @(negedge clk) mosi = b;
        repeat (2) @(negedge clk);
        r = miso;
        sck = 1'b1;
        repeat (3) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
    endtask

    task automatic open_sel(input bit c, input bit d);
        @(negedge clk);
        cfg_sel_n = !c;
        dat_sel_n = !d;
    endtask

    task automatic close_sel();
        @(negedge clk);
        cfg_sel_n = 1'b1;
        dat_sel_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [4:0] a, input logic [7:0] d, input bit both = 0);
        logic [7:0] r;
        open_sel(1, both);
        spi_byte({1'b0, 2'($urandom), a}, r);
        spi_byte(d, r);
        close_sel();
        if (a == 0 && d[7:5] > 3'd4) m_regs[0] = {m_regs[0][7:5], d[4:0]};
        else m_regs[a] = d;
    endtask

    task automatic cfg_rd(input logic [4:0] a, output logic [7:0] d);
        logic [7:0] r;
        open_sel(1, 0);
        spi_byte({1'b1, 2'($urandom), a}, r);
        spi_byte(8'h00, d);
        close_sel();
    endtask

    task automatic cfg_chk(input string req, input logic [4:0] a);
        logic [7:0] d;
        cfg_rd(a, d);
        chk(req, d, m_regs[a]);
    endtask

    // burst of n host data bytes; reads are compared against the model
    task automatic dat_burst(input int n, input string req);
        logic [7:0] r, b, e;
        open_sel(0, 1);
        for (int k = 0; k < n; k++) begin
            b = 8'($urandom);
            if (m_rx()) e = (m_q.size() > 0) ? m_q[0] : 8'h00;
            spi_byte(b, r);
            if (m_rx()) begin
                chk(req, r, e);
                if (m_q.size() > 0) void'(m_q.pop_front());
            end else begin
                m_push(b);
            end
        end
        close_sel();
    endtask

    task automatic rf_push_t(input logic [7:0] b);
        @(negedge clk);
        rf_push = 1'b1;
        rf_push_data = b;
        @(negedge clk);
        rf_push = 1'b0;
        if (m_rx()) m_push(b);
    endtask

    task automatic rf_pop_t(input string req);
        @(negedge clk);
        chk(req, rf_pop_data, (m_q.size() > 0) ? m_q[0] : 8'h00);
        rf_pop = 1'b1;
        @(negedge clk);
        rf_pop = 1'b0;
        if (!m_rx() && m_q.size() > 0) void'(m_q.pop_front());
    endtask

    task automatic status_chk(input string req);
        @(negedge clk);
        chk({req, " count"}, fifo_count, m_q.size());
        chk({req, " full"}, fifo_full, m_q.size() == 64);
        chk({req, " empty"}, fifo_empty, m_q.size() == 0);
        chk({req, " ovf"}, fifo_ovf, m_ovf);
        chk({req, " mode"}, mode_o, m_regs[0][7:5]);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       r;
        void'($urandom(32'd2024));
        for (int i = 0; i < 32; i++) m_regs[i] = 8'h00;
        m_regs[0] = 8'h20;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R4 reset state
        status_chk("R4");
        chk("R3 idle oe", miso_oe, 1'b0);
        chk("R3 idle miso", miso, 1'b0);
        cfg_chk("R4 reg0", 5'd0);
        cfg_chk("R4 reg17", 5'd17);

        // R3 driver enable
        open_sel(1, 0); @(negedge clk); chk("R3 cfg oe", miso_oe, 1'b1);
        close_sel();                     chk("R3 off oe", miso_oe, 1'b0);
        open_sel(0, 1); @(negedge clk); chk("R3 dat oe", miso_oe, 1'b1);
        @(negedge clk); cfg_sel_n = 1'b1; dat_sel_n = 1'b1; repeat (2) @(negedge clk);

        // R1 header format, read back, extra bytes ignored
        cfg_wr(5'd7, 8'hA5);
        cfg_chk("R1 readback", 5'd7);
        open_sel(1, 0);
        spi_byte(8'h09, d); spi_byte(8'h3C, d); spi_byte(8'hFF, d);
        close_sel();
        m_regs[9] = 8'h3C;
        cfg_chk("R1 extra byte", 5'd9);

        // R5 mode decode and illegal codes
        cfg_wr(5'd0, 8'h6B);
        status_chk("R5 rx");
        cfg_wr(5'd0, 8'hBF);
        cfg_chk("R5 illegal", 5'd0);
        status_chk("R5 kept");
        cfg_wr(5'd0, 8'h80);
        status_chk("R5 tx");

        // R6 sleep retains and allows access
        cfg_wr(5'd0, 8'h00);
        cfg_wr(5'd4, 8'h5A);
        cfg_chk("R6 sleep rd", 5'd4);
        chk("R6 sleep mode", mode_o, 3'd0);
        cfg_wr(5'd0, 8'h20);
        cfg_chk("R6 after wake", 5'd4);

        // R2 both selects low
        cfg_wr(5'd3, 8'h11, 1);
        cfg_chk("R2 reg written", 5'd3);
        status_chk("R2 fifo untouched");

        // R8 partial byte discarded
        open_sel(0, 1);
        for (int i = 0; i < 4; i++) spi_bit(1'b1, r);
        close_sel();
        status_chk("R8 partial");
        dat_burst(1, "R8");
        status_chk("R8 whole");

        // R12 order, R7 radio pop side in standby
        dat_burst(3, "R12");
        for (int i = 0; i < 4; i++) rf_pop_t("R12 order");
        status_chk("R12 drained");
        rf_pop_t("R11 empty pop");
        status_chk("R11 empty pop");
        rf_push_t(8'h77);
        status_chk("R7 push ignored");

        // R9 / R10 fill and overflow in one 65-byte burst
        dat_burst(65, "R9");
        status_chk("R10 full");
        rf_pop_t("R10 head");
        status_chk("R9 after pop");

        // R7 receive mode: host reads, radio pushes, radio pop ignored
        cfg_wr(5'd0, 8'h60);
        rf_pop_t("R7 pop ignored");
        status_chk("R7 pop ignored");
        dat_burst(2, "R7 host write ignored");
        status_chk("R7 host write ignored");
        dat_burst(70, "R11 drain past empty");
        status_chk("R11 after drain");
        for (int i = 0; i < 5; i++) rf_push_t(8'($urandom));
        dat_burst(6, "R12 rx order");
        status_chk("R11 empty again");

        // random mix
        for (int it = 0; it < 250; it++) begin
            case ($urandom_range(0, 7))
                0: cfg_wr(5'd0, {3'($urandom_range(0, 7)), 5'($urandom)});
                1: cfg_wr(5'($urandom_range(1, 31)), 8'($urandom));
                2: cfg_chk("R1 random rd", 5'($urandom));
                3: dat_burst($urandom_range(1, 6), "R12 random");
                4: rf_push_t(8'($urandom));
                5: rf_pop_t("R12 random pop");
                6: begin
                    open_sel(0, 1);
                    for (int i = 0; i < $urandom_range(1, 7); i++) spi_bit(1'($urandom), r);
                    close_sel();
                end
                default: status_chk("R9 random status");
            endcase
        end
        status_chk("R10 final");
        summary();
        $finish;
    end
endmodule